// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This controller selects the operating mode of a small microcontroller. Software sets the mode through a six-bit configuration write. The block turns the chosen mode into enable levels for five clock domains: main oscillator, PLL, CPU clock, peripheral clocks and timebase timer. It also drives a select for the divided-main operating clock, a PLL factor, and two pin controls, one to float the pins and one to hold them. Oscillators, the analog PLL and glitch-free clock switching sit outside the block and see only these levels.

There are seven mode codes. Two are run modes, one on the PLL and one on the main oscillator divided by two. Four are low-power modes: two sleep modes, a watch mode and a stop mode. The seventh code is a settling phase that follows stop. An interrupt request ends any low-power mode. Wake-up clears the sleep and halt requests, and the block returns to the run mode that the clock-source bit selects. Leaving stop passes through a settling phase of `STAB_CYCLES` clocks, with the CPU clock held off.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset the block is in main run: `mode_o`=3, `pll_en_o`=0, oscillator, CPU, peripheral and timebase enables at 1, `pll_mult_o`=1, both pin controls at 0 and `low_power_o`=1.
- R2: Write word layout: bit0 clock source (1=main), bit1 sleep request, bit2 halt request, bit3 pin float, bits5:4 multiplier. The `mode_o` codes are 0 PLL run, 1 PLL sleep, 2 watch, 3 main run, 4 main sleep, 5 stop and 6 settling. A halt request with source 0 gives watch, and with source 1 gives stop. A sleep request with source 0 gives PLL sleep, and with source 1 gives main sleep. Halt wins over sleep. The new mode appears at the clock edge that samples the write.
- R3: In both sleep modes only the CPU clock enable is 0. The oscillator, peripheral and timebase enables stay at 1, and the PLL enable stays as it was in the matching run mode.
- R4: In watch mode only the oscillator and timebase enables are 1. The CPU, peripheral and PLL enables are 0.
- R5: In stop mode all five enables are 0.
- R6: PLL run has every enable at 1, with `main_div_sel_o`=0 and `low_power_o`=0. Main run has the PLL enable at 0 and `main_div_sel_o`=1. `low_power_o` is 1 in every mode except PLL run.
- R7: In watch and stop, a pin-float bit of 1 sets `pin_hiz_o`, and a bit of 0 sets `pin_hold_o`. Both pin controls are 0 in all other modes.
- R8: When an interrupt request is present at a clock edge during sleep or watch, that edge clears the sleep and halt requests and enters the run mode given by the clock source. The block then stays in that run mode.
- R9: An interrupt in stop enters settling (code 6) for exactly `STAB_CYCLES` clocks. During settling the CPU and peripheral enables are 0 and the oscillator enable is 1. The block then enters main run.
- R10: `pll_mult_o` equals the multiplier field plus one: 00→1, 01→2, 10→3, 11→4.
- R11: A write is ignored while the CPU clock enable is 0. An interrupt request in a run mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 6 | Configuration word (layout in R2) |
| irq_i | input | 1 | Interrupt request, wake-up source |
| osc_en_o | output | 1 | Main oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| tbt_clk_en_o | output | 1 | Timebase timer clock enable |
| main_div_sel_o | output | 1 | 1 selects main oscillator divided by two |
| pll_mult_o | output | 3 | PLL multiplication factor, 1 to 4 |
| pin_hiz_o | output | 1 | Request to float the pins |
| pin_hold_o | output | 1 | Request to hold the pins at their last state |
| mode_o | output | 3 | Current mode code |
| low_power_o | output | 1 | 1 in every mode except PLL run |

## Verification
The bench builds the controller with `STAB_CYCLES` set to 4. This makes the settling window short enough to check cycle by cycle, so the bench confirms that the CPU clock stays off for exactly four clocks and that main run follows on the fifth edge. All other parameters keep their defaults. The default of 16 uses a wider counter but follows the same path, which the bench already covers at its smaller value.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int CFG_W  = 6;
  localparam int MULT_W = 2;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_PLL_RUN  = 3'd0,
    MODE_PLL_NAP  = 3'd1,
    MODE_WATCH    = 3'd2,
    MODE_MAIN_RUN = 3'd3,
    MODE_MAIN_NAP = 3'd4,
    MODE_STOP     = 3'd5,
    MODE_SETTLE   = 3'd6
  } lpm_mode_e;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic              pin_float;
    logic              halt;
    logic              nap;
    logic              main_src;
  } lpm_cfg_t;

  typedef struct packed {
    logic osc;
    logic pll;
    logic cpu;
    logic per;
    logic tbt;
  } lpm_en_t;

  localparam lpm_cfg_t CFG_RESET = '{mult: '0, pin_float: 1'b0, halt: 1'b0,
                                     nap: 1'b0, main_src: 1'b1};

  function automatic lpm_mode_e lpm_decode(lpm_cfg_t c);
    if (c.halt)     return c.main_src ? MODE_STOP     : MODE_WATCH;
    else if (c.nap) return c.main_src ? MODE_MAIN_NAP : MODE_PLL_NAP;
    else            return c.main_src ? MODE_MAIN_RUN : MODE_PLL_RUN;
  endfunction

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic     wr_acc_i,
  input  lpm_cfg_t wr_data_i,
  input  logic     wake_i,
  output lpm_cfg_t cfg_nxt_o,
  output lpm_cfg_t cfg_q_o
);
  lpm_cfg_t cfg_d, cfg_q;
  logic     cfg_en;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i && wr_acc_i) cfg_d = wr_data_i;
    if (wake_i) begin
      cfg_d.nap  = 1'b0;
      cfg_d.halt = 1'b0;
    end
  end

  assign cfg_en = (wr_en_i && wr_acc_i) || wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_RESET;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_nxt_o = cfg_d;
  assign cfg_q_o   = cfg_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  lpm_cfg_t  cfg_nxt_i,
  input  logic      irq_i,
  output lpm_mode_e mode_o,
  output logic      wake_o
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAB_CYCLES - 1);

  lpm_mode_e        mode_d, mode_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en, dormant;

  assign dormant = (mode_q == MODE_PLL_NAP) || (mode_q == MODE_MAIN_NAP) ||
                   (mode_q == MODE_WATCH)   || (mode_q == MODE_STOP);
  assign wake_o  = dormant && irq_i;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (mode_q == MODE_SETTLE) begin
      if (cnt_q == '0) begin
        mode_d = MODE_MAIN_RUN;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end else if (wake_o && (mode_q == MODE_STOP)) begin
      mode_d = MODE_SETTLE;
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
    end else begin
      mode_d = lpm_decode(cfg_nxt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_MAIN_RUN;
    else         mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_i,
  input  logic      pin_float_i,
  output lpm_en_t   en_o,
  output logic      pin_hiz_o,
  output logic      pin_hold_o
);
  logic deep;

  always_comb begin
    unique case (mode_i)
      MODE_PLL_RUN:  en_o = '{osc: 1'b1, pll: 1'b1, cpu: 1'b1, per: 1'b1, tbt: 1'b1};
      MODE_PLL_NAP:  en_o = '{osc: 1'b1, pll: 1'b1, cpu: 1'b0, per: 1'b1, tbt: 1'b1};
      MODE_WATCH:    en_o = '{osc: 1'b1, pll: 1'b0, cpu: 1'b0, per: 1'b0, tbt: 1'b1};
      MODE_MAIN_RUN: en_o = '{osc: 1'b1, pll: 1'b0, cpu: 1'b1, per: 1'b1, tbt: 1'b1};
      MODE_MAIN_NAP: en_o = '{osc: 1'b1, pll: 1'b0, cpu: 1'b0, per: 1'b1, tbt: 1'b1};
      MODE_SETTLE:   en_o = '{osc: 1'b1, pll: 1'b0, cpu: 1'b0, per: 1'b0, tbt: 1'b1};
      default:       en_o = '0;
    endcase
  end

  assign deep       = (mode_i == MODE_WATCH) || (mode_i == MODE_STOP);
  assign pin_hiz_o  = deep && pin_float_i;
  assign pin_hold_o = deep && !pin_float_i;
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic              irq_i,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              tbt_clk_en_o,
  output logic              main_div_sel_o,
  output logic [2:0]        pll_mult_o,
  output logic              pin_hiz_o,
  output logic              pin_hold_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              low_power_o
);
  logic      rst_sync_n, wake;
  lpm_cfg_t  cfg_nxt, cfg_q;
  lpm_mode_e mode;
  lpm_en_t   en;

  lpm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  lpm_cfg_reg u_cfg_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_acc_i  (en.cpu),
    .wr_data_i (lpm_cfg_t'(wr_data_i)),
    .wake_i    (wake),
    .cfg_nxt_o (cfg_nxt),
    .cfg_q_o   (cfg_q)
  );

  lpm_mode_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_mode_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cfg_nxt_i (cfg_nxt),
    .irq_i     (irq_i),
    .mode_o    (mode),
    .wake_o    (wake)
  );

  lpm_clk_decode u_clk_decode (
    .mode_i      (mode),
    .pin_float_i (cfg_q.pin_float),
    .en_o        (en),
    .pin_hiz_o   (pin_hiz_o),
    .pin_hold_o  (pin_hold_o)
  );

  assign osc_en_o       = en.osc;
  assign pll_en_o       = en.pll;
  assign cpu_clk_en_o   = en.cpu;
  assign per_clk_en_o   = en.per;
  assign tbt_clk_en_o   = en.tbt;
  assign main_div_sel_o = !en.pll;
  assign pll_mult_o     = {1'b0, cfg_q.mult} + 3'd1;
  assign mode_o         = mode;
  assign low_power_o    = (mode != MODE_PLL_RUN);
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_i,
  input logic       osc_en_o,
  input logic       pll_en_o,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       tbt_clk_en_o,
  input logic [2:0] pll_mult_o,
  input logic       pin_hiz_o,
  input logic       pin_hold_o,
  input logic [2:0] mode_o
);
  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 3'd7);

  p_nap_cpu_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 || mode_o == 3'd4) |-> (!cpu_clk_en_o && per_clk_en_o && osc_en_o && tbt_clk_en_o));

  p_watch_tbt_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> (tbt_clk_en_o && !cpu_clk_en_o && !per_clk_en_o && !pll_en_o));

  p_stop_all_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |-> (!osc_en_o && !pll_en_o && !cpu_clk_en_o && !per_clk_en_o && !tbt_clk_en_o));

  p_pins_deep_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_hiz_o || pin_hold_o) |-> ((mode_o == 3'd2 || mode_o == 3'd5) && !(pin_hiz_o && pin_hold_o)));

  p_wake_to_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd1 || mode_o == 3'd2 || mode_o == 3'd4) && irq_i) |=> (mode_o == 3'd0 || mode_o == 3'd3));

  p_stop_wake_settle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && irq_i) |=> (mode_o == 3'd6 && !cpu_clk_en_o && osc_en_o));

  p_mult_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_mult_o >= 3'd1 && pll_mult_o <= 3'd4));

  p_no_write_when_cpu_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_clk_en_o |=> $stable(pll_mult_o));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_lpm_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_i        (irq_i),
  .osc_en_o     (osc_en_o),
  .pll_en_o     (pll_en_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .tbt_clk_en_o (tbt_clk_en_o),
  .pll_mult_o   (pll_mult_o),
  .pin_hiz_o    (pin_hiz_o),
  .pin_hold_o   (pin_hold_o),
  .mode_o       (mode_o)
);

// File: tb/test_lpm_clk_ctrl.sv
module test_lpm_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STAB       = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [5:0] wr_data_i;
  logic       irq_i;
  logic       osc_en_o, pll_en_o, cpu_clk_en_o, per_clk_en_o, tbt_clk_en_o;
  logic       main_div_sel_o, pin_hiz_o, pin_hold_o, low_power_o;
  logic [2:0] pll_mult_o, mode_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lpm_clk_ctrl #(.STAB_CYCLES(STAB)) i_lpm_clk_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .irq_i,
    .osc_en_o, .pll_en_o, .cpu_clk_en_o, .per_clk_en_o, .tbt_clk_en_o,
    .main_div_sel_o, .pll_mult_o, .pin_hiz_o, .pin_hold_o, .mode_o, .low_power_o
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // enables packed as {osc,pll,cpu,per,tbt}
  function automatic int en_vec();
    return {osc_en_o, pll_en_o, cpu_clk_en_o, per_clk_en_o, tbt_clk_en_o};
  endfunction

  // word: {mult[1:0], float, halt, nap, main}
  task automatic do_write(logic [5:0] w);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = w;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_irq();
    @(negedge clk_i);
    irq_i = 1'b1;
    @(negedge clk_i);
    irq_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_data_i = '0; irq_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 mode", mode_o, 3);
    chk("R1 enables", en_vec(), 5'b10111);
    chk("R1 mult", pll_mult_o, 1);
    chk("R1 pins", {pin_hiz_o, pin_hold_o}, 0);
    chk("R1 low_power", low_power_o, 1);
  endtask

  task automatic t_pll_run_and_mult();
    do_write(6'b00_0000);
    chk("R6 pll run mode", mode_o, 0);
    chk("R6 pll run enables", en_vec(), 5'b11111);
    chk("R6 src sel", main_div_sel_o, 0);
    chk("R6 low_power", low_power_o, 0);
    do_write(6'b11_0000);
    chk("R10 mult 11", pll_mult_o, 4);
    do_write(6'b01_0000);
    chk("R10 mult 01", pll_mult_o, 2);
    do_write(6'b10_0000);
    chk("R10 mult 10", pll_mult_o, 3);
  endtask

  task automatic t_pll_sleep();
    do_write(6'b10_0010);
    chk("R2 pll sleep code", mode_o, 1);
    chk("R3 pll sleep enables", en_vec(), 5'b11011);
    do_irq();
    chk("R8 wake to pll run", mode_o, 0);
    repeat (2) @(negedge clk_i);
    chk("R8 stays in run", mode_o, 0);
  endtask

  task automatic t_main_sleep();
    do_write(6'b00_0011);
    chk("R2 main sleep code", mode_o, 4);
    chk("R3 main sleep enables", en_vec(), 5'b10011);
    do_irq();
    chk("R8 wake to main run", mode_o, 3);
    chk("R6 main run enables", en_vec(), 5'b10111);
    chk("R6 main src sel", main_div_sel_o, 1);
  endtask

  task automatic t_watch_float();
    do_write(6'b00_1100);
    chk("R2 watch code", mode_o, 2);
    chk("R4 watch enables", en_vec(), 5'b10001);
    chk("R7 watch float", {pin_hiz_o, pin_hold_o}, 2'b10);
    do_write(6'b11_0101);
    chk("R11 write ignored mode", mode_o, 2);
    chk("R11 write ignored mult", pll_mult_o, 1);
    do_irq();
    chk("R8 watch wake to pll run", mode_o, 0);
    chk("R7 pins released", {pin_hiz_o, pin_hold_o}, 0);
  endtask

  task automatic t_stop_hold();
    do_write(6'b00_0111);
    chk("R2 halt beats sleep", mode_o, 5);
    chk("R5 stop enables", en_vec(), 0);
    chk("R7 stop hold", {pin_hiz_o, pin_hold_o}, 2'b01);
    do_irq();
    for (int i = 0; i < STAB; i++) begin
      chk("R9 settling code", mode_o, 6);
      chk("R9 settling enables", en_vec(), 5'b10001);
      @(negedge clk_i);
    end
    chk("R9 main run after settle", mode_o, 3);
    chk("R9 cpu on after settle", cpu_clk_en_o, 1);
  endtask

  task automatic t_irq_in_run();
    do_irq();
    chk("R11 irq in run", mode_o, 3);
    chk("R11 irq in run enables", en_vec(), 5'b10111);
  endtask

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_report();
  end

  initial begin
    t_reset();
    t_pll_run_and_mult();
    t_pll_sleep();
    t_main_sleep();
    t_watch_float();
    t_stop_hold();
    t_irq_in_run();
    finish_report();
  end
endmodule